// File: doc/BRIEF.md
# SPI Register-Access Controller with Wait-State Polling

This block runs one register read or register write against an SPI peripheral that may hold off the data phase with wait states. A host pulses `start` with a direction, a payload length of 1 to 64 bytes and a 24-bit register address. The controller lowers chip select and clocks out a four-byte header: a command byte followed by the address. It then inspects the least significant bit of the byte that came back on MISO during the last header byte.

A 0 in that bit means the peripheral is not ready. The controller then keeps clocking filler bytes and tests the same bit of each returned byte, until the bit reads 1 or a programmable number of wait bytes has gone by. Once the peripheral releases, a write takes its payload from a valid/ready byte stream and shifts it out. A read shifts in the payload and hands each byte to the host with a one-cycle strobe. In the data phase no more wait bits are tested. The SPI clock is the system clock divided by a fixed parameter, and the bus uses mode 0.

Top module: `regspi_ctrl`

## Requirements
- R1: The first four bytes on MOSI are the command byte {bit7 = 1 for read and 0 for write, bit6 = 0, bits5:0 = length-1}, followed by address bits 23:16, 15:8 and 7:0 in that order. All bytes are sent MSB first.
- R2: Every length from 1 to 64 moves exactly that many payload bytes, with `len_m1` holding length-1.
- R3: If bit 0 of the fourth byte received on MISO is 1, the payload starts with the fifth byte, giving 4+length bytes in total.
- R4: Each received wait byte whose bit 0 is 0 adds one more filler byte. A release after N wait bytes gives 4+N+length bytes in total.
- R5: In a write, `wr_ready` is high only while the controller waits for the next payload byte. Exactly `length` bytes are accepted and are sent on MOSI in the order they were accepted.
- R6: In a read, the payload bytes from MISO appear on `rd_data`, each with a one-cycle `rd_valid`, `length` of them in order. Their bit 0 has no effect on the byte count.
- R7: If N wait bytes have been clocked (N = `wait_limit`, sampled at start) and the last one still has bit 0 = 0, the transaction ends after 4+N bytes with `err` high alongside `done`. No payload moves in that case. With N = 0, any stall ends the transaction right after the header.
- R8: Every filler byte is 0x00. Filler bytes are the wait bytes of both directions and all data-phase bytes of a read.
- R9: Chip select (`cs_n`, active low) stays low without a break from before the first SCLK rise until after the last SCLK fall. `done` is a single-cycle pulse, and it is high in the first cycle in which `cs_n` is high again.
- R10: After reset, `cs_n`=1, `sclk`=0, `busy`=0, `done`=0 and `wr_ready`=0.
- R11: SCLK idles low and never rises while `cs_n` is high. MOSI does not change while SCLK is high. A `start` pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Launch one transaction (ignored while busy) |
| rd_req | input | 1 | 1 = register read, 0 = register write |
| len_m1 | input | 6 | Payload length minus one |
| addr | input | 24 | Register address |
| wait_limit | input | 8 | Largest number of wait bytes before giving up |
| wr_data | input | 8 | Write payload stream data |
| wr_valid | input | 1 | Write stream byte available |
| wr_ready | output | 1 | Controller takes `wr_data` when both are high |
| rd_data | output | 8 | Read payload byte |
| rd_valid | output | 1 | `rd_data` holds a new byte this cycle |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| err | output | 1 | With `done`: wait limit reached without release |
| cs_n | output | 1 | SPI chip select, active low |
| sclk | output | 1 | SPI clock, mode 0 |
| mosi | output | 1 | Controller-to-peripheral data |
| miso | input | 1 | Peripheral-to-controller data |

## Verification
A sequencer that loses track of the header index or the wait count shows up as a wrong total byte count. It can also show up as a wrong byte under chip select, or as a missing or misplaced MOSI byte, all visible before `done` is seen. A wrong decision on the release bit, such as testing it in the data phase or ignoring it, shifts the payload by whole bytes. That appears straight away in the first captured data byte and in the `rd_valid` count. A timeout counter that is off by one changes the byte count of the failing transaction and the `err` flag that comes with `done`. A direction mix-up produces write pops during a read, or read strobes during a write, within the first payload byte.

// File: rtl/regspi_pkg.sv
// Package: shared types and helpers for the SPI register-access controller.
// Assumes an 8-bit command byte with a 6-bit length-minus-one field.
package regspi_pkg;

    localparam int          LEN_W     = 6;
    localparam logic [7:0]  FILL_BYTE = 8'h00;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_HEAD,
        SQ_POLL,
        SQ_WFETCH,
        SQ_MOVE
    } seq_state_t;

    // Builds the command byte: read flag on top, length-1 in the low bits.
    function automatic logic [7:0] make_cmd(input logic is_read,
                                            input logic [LEN_W-1:0] lm1);
        return {is_read, 1'b0, lm1};
    endfunction

endpackage

// File: rtl/regspi_byte_io.sv
// Module: regspi_byte_io
// Shifts one byte each way on a mode-0 SPI bus per `go` pulse. SCLK is low
// for DIV_HALF system cycles and then high for DIV_HALF. MISO is sampled on
// the rising edge and MOSI moves on the falling edge. `byte_done` pulses one
// cycle after the eighth falling edge, with the received byte in `rx_byte`.
// Assumes `go` is only pulsed while `active` is low.
module regspi_byte_io #(
    parameter int DIV_HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       byte_done,
    output logic [7:0] rx_byte,
    output logic       active
);

    localparam int DIV_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

    logic [DIV_W-1:0] div_cnt;
    logic [2:0]       bit_idx;
    logic [7:0]       tx_sh;
    logic [7:0]       rx_sh;
    logic             phase_end;

    // End of one SCLK half period.
    assign phase_end = (div_cnt == DIV_W'(DIV_HALF - 1));

    // Bit timing, shifting and byte completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            sclk      <= 1'b0;
            mosi      <= 1'b0;
            byte_done <= 1'b0;
            rx_byte   <= 8'h00;
            div_cnt   <= '0;
            bit_idx   <= 3'd0;
            tx_sh     <= 8'h00;
            rx_sh     <= 8'h00;
        end else begin
            byte_done <= 1'b0;
            if (!active) begin
                if (go) begin
                    active  <= 1'b1;
                    tx_sh   <= tx_byte;
                    mosi    <= tx_byte[7];
                    bit_idx <= 3'd0;
                    div_cnt <= '0;
                    sclk    <= 1'b0;
                end
            end else if (!phase_end) begin
                div_cnt <= div_cnt + 1'b1;
            end else begin
                div_cnt <= '0;
                if (!sclk) begin
                    sclk  <= 1'b1;
                    rx_sh <= {rx_sh[6:0], miso};
                end else begin
                    sclk <= 1'b0;
                    if (bit_idx == 3'd7) begin
                        active    <= 1'b0;
                        byte_done <= 1'b1;
                        rx_byte   <= rx_sh;
                    end else begin
                        bit_idx <= bit_idx + 1'b1;
                        tx_sh   <= {tx_sh[6:0], 1'b0};
                        mosi    <= tx_sh[6];
                    end
                end
            end
        end
    end

    // MOSI is held for the whole high phase of SCLK.
    p_mosi_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    // SCLK rests low whenever no byte is in flight.
    p_sclk_rest_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !sclk);

endmodule

// File: rtl/regspi_seq.sv
// Module: regspi_seq
// Transaction sequencer. It issues the command and address bytes, then polls
// bit 0 of each received byte until release or until the wait limit is
// reached. It then runs the payload through the write stream or out to the
// read strobe. Assumes one byte engine that acknowledges each `io_go` with
// exactly one `io_done`.
module regspi_seq
    import regspi_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rd_req,
    input  logic [LEN_W-1:0]  len_m1,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WAIT_W-1:0] wait_limit,
    input  logic [7:0]        wr_data,
    input  logic              wr_valid,
    output logic              wr_ready,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              cs_act,
    output logic              io_go,
    output logic [7:0]        io_tx,
    input  logic              io_done,
    input  logic [7:0]        io_rx
);

    localparam int ADDR_BYTES = ADDR_W / 8;
    localparam int HDR_W      = $clog2(ADDR_BYTES + 1);

    seq_state_t        st;
    logic              rd_q;
    logic [LEN_W-1:0]  len_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WAIT_W-1:0] wlim_q;
    logic [WAIT_W-1:0] wait_cnt;
    logic [HDR_W-1:0]  hdr_idx;
    logic [LEN_W-1:0]  pay_idx;
    logic [7:0]        addr_bytes [ADDR_BYTES];

    // Splits the latched address into bytes, most significant first.
    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_addr_byte
        assign addr_bytes[g] = addr_q[ADDR_W-1-8*g -: 8];
    end

    // Stream ready and busy come from the state alone.
    assign wr_ready = (st == SQ_WFETCH);
    assign busy     = (st != SQ_IDLE);

    // Transaction state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= SQ_IDLE;
            rd_q     <= 1'b0;
            len_q    <= '0;
            addr_q   <= '0;
            wlim_q   <= '0;
            wait_cnt <= '0;
            hdr_idx  <= '0;
            pay_idx  <= '0;
            cs_act   <= 1'b0;
            io_go    <= 1'b0;
            io_tx    <= 8'h00;
            rd_data  <= 8'h00;
            rd_valid <= 1'b0;
            done     <= 1'b0;
            err      <= 1'b0;
        end else begin
            io_go    <= 1'b0;
            rd_valid <= 1'b0;
            done     <= 1'b0;
            err      <= 1'b0;
            case (st)
                SQ_IDLE: begin
                    if (start) begin
                        rd_q     <= rd_req;
                        len_q    <= len_m1;
                        addr_q   <= addr;
                        wlim_q   <= wait_limit;
                        wait_cnt <= '0;
                        hdr_idx  <= '0;
                        cs_act   <= 1'b1;
                        io_tx    <= make_cmd(rd_req, len_m1);
                        io_go    <= 1'b1;
                        st       <= SQ_HEAD;
                    end
                end
                SQ_HEAD: begin
                    if (io_done) begin
                        if (hdr_idx != HDR_W'(ADDR_BYTES)) begin
                            io_tx   <= addr_bytes[hdr_idx];
                            io_go   <= 1'b1;
                            hdr_idx <= hdr_idx + 1'b1;
                        end else if (io_rx[0]) begin
                            pay_idx <= '0;
                            if (rd_q) begin
                                io_tx <= FILL_BYTE;
                                io_go <= 1'b1;
                                st    <= SQ_MOVE;
                            end else begin
                                st <= SQ_WFETCH;
                            end
                        end else if (wlim_q == '0) begin
                            cs_act <= 1'b0;
                            done   <= 1'b1;
                            err    <= 1'b1;
                            st     <= SQ_IDLE;
                        end else begin
                            io_tx    <= FILL_BYTE;
                            io_go    <= 1'b1;
                            wait_cnt <= WAIT_W'(1);
                            st       <= SQ_POLL;
                        end
                    end
                end
                SQ_POLL: begin
                    if (io_done) begin
                        if (io_rx[0]) begin
                            pay_idx <= '0;
                            if (rd_q) begin
                                io_tx <= FILL_BYTE;
                                io_go <= 1'b1;
                                st    <= SQ_MOVE;
                            end else begin
                                st <= SQ_WFETCH;
                            end
                        end else if (wait_cnt == wlim_q) begin
                            cs_act <= 1'b0;
                            done   <= 1'b1;
                            err    <= 1'b1;
                            st     <= SQ_IDLE;
                        end else begin
                            wait_cnt <= wait_cnt + 1'b1;
                            io_tx    <= FILL_BYTE;
                            io_go    <= 1'b1;
                        end
                    end
                end
                SQ_WFETCH: begin
                    if (wr_valid) begin
                        io_tx <= wr_data;
                        io_go <= 1'b1;
                        st    <= SQ_MOVE;
                    end
                end
                SQ_MOVE: begin
                    if (io_done) begin
                        if (rd_q) begin
                            rd_data  <= io_rx;
                            rd_valid <= 1'b1;
                        end
                        if (pay_idx == len_q) begin
                            cs_act <= 1'b0;
                            done   <= 1'b1;
                            st     <= SQ_IDLE;
                        end else begin
                            pay_idx <= pay_idx + 1'b1;
                            if (rd_q) begin
                                io_tx <= FILL_BYTE;
                                io_go <= 1'b1;
                            end else begin
                                st <= SQ_WFETCH;
                            end
                        end
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    // Wait counter stays inside 1..limit while polling.
    p_wait_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_POLL) |-> (wait_cnt != '0 && wait_cnt <= wlim_q));

    // An error is only reported together with the end of a transaction.
    p_err_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    // Read strobes only occur in read transactions.
    p_rd_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> rd_q);

    // Write stream is only consulted in write transactions, within length.
    p_wr_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> (!rd_q && pay_idx <= len_q));

endmodule

// File: rtl/regspi_ctrl.sv
// Module: regspi_ctrl (top)
// SPI register-access controller with wait-state polling. It ties the
// sequencer to the byte engine and drives active-low chip select.
// Assumes `miso` is already synchronous to `clk`, or slow enough that
// sampling on the SCLK rise is safe.
module regspi_ctrl
    import regspi_pkg::*;
#(
    parameter int DIV_HALF = 2,
    parameter int ADDR_W   = 24,
    parameter int WAIT_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rd_req,
    input  logic [LEN_W-1:0]  len_m1,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WAIT_W-1:0] wait_limit,
    input  logic [7:0]        wr_data,
    input  logic              wr_valid,
    output logic              wr_ready,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              cs_n,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso
);

    logic       cs_act;
    logic       io_go;
    logic [7:0] io_tx;
    logic       io_done;
    logic [7:0] io_rx;
    logic       io_active;

    // Chip select is the inverse of the sequencer's select register.
    assign cs_n = ~cs_act;

    regspi_seq #(
        .ADDR_W (ADDR_W),
        .WAIT_W (WAIT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .rd_req     (rd_req),
        .len_m1     (len_m1),
        .addr       (addr),
        .wait_limit (wait_limit),
        .wr_data    (wr_data),
        .wr_valid   (wr_valid),
        .wr_ready   (wr_ready),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .busy       (busy),
        .done       (done),
        .err        (err),
        .cs_act     (cs_act),
        .io_go      (io_go),
        .io_tx      (io_tx),
        .io_done    (io_done),
        .io_rx      (io_rx)
    );

    regspi_byte_io #(
        .DIV_HALF (DIV_HALF)
    ) u_byte_io (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (io_go),
        .tx_byte   (io_tx),
        .miso      (miso),
        .sclk      (sclk),
        .mosi      (mosi),
        .byte_done (io_done),
        .rx_byte   (io_rx),
        .active    (io_active)
    );

    // Chip select stays low while any byte is moving.
    p_cs_during_io_r9: assert property (@(posedge clk) disable iff (!rst_n)
        io_active |-> !cs_n);

    // Done coincides with the first cycle of released chip select.
    p_done_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && !$past(cs_n)));

    // Done is a single-cycle pulse.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // With no transaction in progress the bus is idle.
    p_idle_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done) |-> (cs_n && !sclk));

endmodule

// File: tb/regspi_ctrl_bench.sv
module regspi_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rd_req = 1'b0;
    logic [5:0]  len_m1 = '0;
    logic [23:0] addr = '0;
    logic [7:0]  wait_limit = '0;
    logic [7:0]  wr_data;
    logic        wr_valid = 1'b1;
    logic        wr_ready, rd_valid, busy, done, err, cs_n, sclk, mosi;
    logic [7:0]  rd_data;
    logic        miso = 1'b0;

    always #5 clk = ~clk;

    regspi_ctrl u_regspi_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_req(rd_req),
        .len_m1(len_m1), .addr(addr), .wait_limit(wait_limit),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .done(done),
        .err(err), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    int n_tests = 0;
    int n_fail  = 0;

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Peripheral model: shifts MISO on SCLK falls, logs MOSI on rises.
    logic [7:0] resp [0:255];
    logic [7:0] mlog [0:255];
    int         nbytes = 0;
    int         bitpos = 0;
    int         rises_idle = 0;
    logic [7:0] psh = 8'h00;

    always @(negedge cs_n) begin
        nbytes = 0;
        bitpos = 0;
        miso   = resp[0][7];
    end
    always @(posedge sclk) begin
        if (cs_n) rises_idle++;
        else begin
            psh = {psh[6:0], mosi};
            bitpos++;
            if (bitpos == 8) begin
                mlog[nbytes] = psh;
                nbytes++;
                bitpos = 0;
            end
        end
    end
    always @(negedge sclk) if (!cs_n) miso = resp[nbytes][7 - bitpos];

    // Host model: write stream source and read/done capture.
    logic       clr = 1'b0;
    logic [7:0] seed_q = 8'h00;
    int         wr_idx = 0, rd_cnt = 0, done_cnt = 0;
    logic       err_seen = 1'b0, cs_at_done = 1'b0;
    logic [7:0] rdlog [0:127];

    assign wr_data = seed_q + 8'(wr_idx);

    always @(posedge clk) begin
        if (clr) begin
            wr_idx <= 0; rd_cnt <= 0; done_cnt <= 0;
            err_seen <= 1'b0; cs_at_done <= 1'b0;
        end else begin
            if (wr_valid && wr_ready) wr_idx <= wr_idx + 1;
            if (rd_valid) begin
                rdlog[rd_cnt] <= rd_data;
                rd_cnt <= rd_cnt + 1;
            end
            if (done) begin
                done_cnt   <= done_cnt + 1;
                err_seen   <= err;
                cs_at_done <= cs_n;
            end
        end
    end

    // Vector: {rd, len_m1[5:0], addr[23:0], stall[7:0], wait_limit[7:0], seed[7:0]}
    localparam int NVEC = 8;
    localparam logic [54:0] VEC [NVEC] = '{
        {1'b0, 6'd3,  24'hAABBCC, 8'd3, 8'd8, 8'h11},  // write, 3 waits (R4)
        {1'b1, 6'd3,  24'hAABBCC, 8'd3, 8'd8, 8'h11},  // read, 3 waits (R4)
        {1'b0, 6'd0,  24'h012345, 8'd0, 8'd0, 8'h40},  // write len 1, no wait (R3)
        {1'b1, 6'd63, 24'h00FF10, 8'd1, 8'd2, 8'h02},  // read len 64 (R2)
        {1'b0, 6'd63, 24'h800001, 8'd0, 8'd3, 8'h80},  // write len 64 (R2)
        {1'b1, 6'd1,  24'h7FFFFE, 8'd5, 8'd5, 8'hC3},  // release at limit (R7)
        {1'b0, 6'd2,  24'h135790, 8'd4, 8'd3, 8'h21},  // timeout (R7)
        {1'b1, 6'd7,  24'hFEDCBA, 8'd2, 8'd0, 8'h5C}   // zero limit timeout (R7)
    };

    task automatic launch(input logic r, input logic [5:0] lm1, input logic [23:0] a,
                          input logic [7:0] wl);
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        rd_req = r; len_m1 = lm1; addr = a; wait_limit = wl; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int cyc = 0;
        while (done_cnt == 0 && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        if (done_cnt == 0) check("R9", "watchdog expired", 0, 1);
        repeat (4) @(negedge clk);
    endtask

    task automatic run_vec(input logic [54:0] v);
        logic       r;
        logic [5:0] lm1;
        logic [23:0] a;
        int stall, wl, len, total, bad_fill, bad_pay, nfill;
        logic [7:0] sd;
        bit to;
        r = v[54]; lm1 = v[53:48]; a = v[47:24];
        stall = int'(v[23:16]); wl = int'(v[15:8]); sd = v[7:0];
        len = int'(lm1) + 1;
        to = (stall > wl);
        for (int i = 0; i < 256; i++) resp[i] = 8'hA5;
        resp[3] = (stall == 0) ? 8'h5B : 8'h5A;
        for (int k = 1; k <= stall; k++) resp[3 + k] = (k == stall) ? 8'h81 : 8'hFE;
        for (int i = 0; i < len; i++) resp[4 + stall + i] = r ? (sd + 8'(i)) : 8'h32;
        seed_q = sd;
        launch(r, lm1, a, 8'(wl));
        wait_done();
        total = to ? (4 + wl) : (4 + stall + len);
        check("R1", "header bytes", {mlog[0], mlog[1], mlog[2], mlog[3]},
              {r, 1'b0, lm1, a});
        check(stall == 0 ? "R3" : "R4", "total bytes", nbytes, total);
        check("R7", "err flag", err_seen, to);
        check("R9", "cs_n high at done", cs_at_done, 1);
        check("R9", "done pulses", done_cnt, 1);
        nfill = to ? wl : stall;
        bad_fill = 0;
        for (int i = 0; i < nfill; i++) if (mlog[4 + i] != 8'h00) bad_fill++;
        if (r && !to) for (int i = 0; i < len; i++) if (mlog[4 + stall + i] != 8'h00) bad_fill++;
        check("R8", "nonzero filler bytes", bad_fill, 0);
        bad_pay = 0;
        if (r) begin
            check("R6", "read strobes", rd_cnt, to ? 0 : len);
            check("R5", "write pops in read", wr_idx, 0);
            if (!to) for (int i = 0; i < len; i++) if (rdlog[i] != sd + 8'(i)) bad_pay++;
            check("R6", "read data mismatches", bad_pay, 0);
        end else begin
            check("R5", "write pops", wr_idx, to ? 0 : len);
            check("R6", "read strobes in write", rd_cnt, 0);
            if (!to) for (int i = 0; i < len; i++) if (mlog[4 + stall + i] != sd + 8'(i)) bad_pay++;
            check(len == 64 ? "R2" : "R5", "write data mismatches", bad_pay, 0);
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check("R10", "cs_n", cs_n, 1);
        check("R10", "sclk", sclk, 0);
        check("R10", "busy", busy, 0);
        check("R10", "done", done, 0);
        check("R10", "wr_ready", wr_ready, 0);

        for (int n = 0; n < NVEC; n++) run_vec(VEC[n]);

        // R11: start while busy is ignored
        for (int i = 0; i < 256; i++) resp[i] = 8'hA5;
        resp[3] = 8'h5A; resp[4] = 8'h81;
        seed_q = 8'h70;
        launch(1'b0, 6'd1, 24'h0A0B0C, 8'd4);
        repeat (40) @(negedge clk);
        rd_req = 1'b1; len_m1 = 6'd9; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        repeat (60) @(negedge clk);
        check("R11", "bytes with start while busy", nbytes, 7);
        check("R11", "done pulses with start while busy", done_cnt, 1);
        check("R11", "cs_n after ignored start", cs_n, 1);

        // R5: write stream withheld stalls the data phase without losing bytes
        resp[3] = 8'h5B;
        seed_q = 8'h90;
        wr_valid = 1'b0;
        launch(1'b0, 6'd2, 24'h111111, 8'd1);
        repeat (200) @(negedge clk);
        check("R5", "bytes while stream empty", nbytes, 4);
        check("R9", "cs_n held while stream empty", cs_n, 0);
        wr_valid = 1'b1;
        wait_done();
        check("R5", "bytes after stream resumes", nbytes, 7);
        check("R5", "last write byte", mlog[6], 8'h92);

        check("R11", "SCLK rises with cs_n high", rises_idle, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Global watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R9 global watchdog actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule